// File: doc/BRIEF.md
# General-Purpose Register File with Pointer Pairs and Data-Space Window

This block holds the 32 working registers of a small 8-bit processor core, each 8 bits wide. In one clock cycle the arithmetic unit can read two operands and write one result back. A result is either a single byte or a 16-bit value that fills an even/odd register pair. Reads are combinational on the current contents. Writes take effect at the rising clock edge.

The six highest registers also act as three 16-bit address pointers. A dedicated port reads or loads a whole pointer at once. The registers also sit at the bottom of a 16-bit linear data address space, so ordinary loads and stores can reach them, including through a pointer. A fixed decoder classifies each data address into one of four regions: register window, short I/O space, extended I/O space or SRAM. For the short I/O space it also gives the region-relative I/O index.

Top module: `gpr_file`

## Requirements
- R1: After reset every one of the 32 registers reads as zero.
- R2: `rd_a_data` and `rd_b_data` show, in the same cycle, the current contents of the registers selected by `rd_a_sel` and `rd_b_sel`. A register that nothing writes keeps its value.
- R3: With `wr_en`=1 and `wr_wide`=0, `wr_data[7:0]` is stored into register `wr_sel` at the clock edge. A read of that register in the same cycle returns the old value, because there is no write-through bypass.
- R4: With `wr_en`=1 and `wr_wide`=1, `wr_data[7:0]` goes to the even register `{wr_sel[4:1],0}` and `wr_data[15:8]` to the odd register `{wr_sel[4:1],1}`, both at the same edge. Bit 0 of `wr_sel` is ignored.
- R5: `rd_pair_data` is `{reg[{rd_a_sel[4:1],1}], reg[{rd_a_sel[4:1],0}]}`, the 16-bit pair that contains operand A.
- R6: `ptr_sel` codes 0, 1 and 2 select register pairs 27:26, 29:28 and 31:30, with the lower-numbered register as the low byte. `ptr_rdata` returns the selected pair. `ptr_we` loads `ptr_wdata` into both bytes of the pair at one edge.
- R7: `ptr_sel`=3 selects no pointer. `ptr_rdata` is then 0 and `ptr_we` changes no register.
- R8: A data address below 0x20 maps to register n = address. `ds_rdata` returns its contents, and `ds_we` stores `ds_wdata` into it. For any address of 0x20 or above, `ds_rdata` is 0 and `ds_we` changes no register.
- R9: Exactly one of `sel_regs` (0x0000–0x001F), `sel_io` (0x0020–0x005F), `sel_xio` (0x0060–0x00FF) or `sel_sram` (0x0100–0xFFFF) is high for every `ds_addr`.
- R10: `io_addr` equals `ds_addr` − 0x20, in 6 bits, while `sel_io` is high, and is 0 otherwise.
- R11: When several write ports hit the same register in one cycle, the result port wins over the pointer port, and the pointer port wins over the data-space port. This holds byte by byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_sel | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A contents |
| rd_b_sel | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B contents |
| rd_pair_data | output | 16 | Register pair containing operand A |
| wr_en | input | 1 | Result write enable |
| wr_wide | input | 1 | 1: 16-bit pair write, 0: byte write |
| wr_sel | input | 5 | Result destination index |
| wr_data | input | 16 | Result value (low byte only for byte writes) |
| ptr_sel | input | 2 | Pointer select: 0, 1, 2 pairs; 3 none |
| ptr_we | input | 1 | Pointer load enable |
| ptr_wdata | input | 16 | New pointer value |
| ptr_rdata | output | 16 | Selected pointer value |
| ds_addr | input | 16 | Linear data address |
| ds_we | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write byte |
| ds_rdata | output | 8 | Register contents at a register-window address, else 0 |
| sel_regs | output | 1 | Address is in the register window |
| sel_io | output | 1 | Address is in the short I/O space |
| sel_xio | output | 1 | Address is in the extended I/O space |
| sel_sram | output | 1 | Address is in SRAM |
| io_addr | output | 6 | I/O index relative to the start of the short I/O space |

## Verification
Every read, pointer and decode output is combinational, so it is due in the cycle its inputs are applied. A write is due one clock edge later, in the cycle after it is driven. The driver changes inputs 2 ns after a rising edge and queues the values expected for that cycle. The monitor compares them at the following falling edge, so every comparison sees settled inputs and state that already includes the previous edge's writes. For the same-cycle read of a written register, the check expects the old contents (R3). Each write is confirmed by reads in the next cycle.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int GPR_COUNT = 32;
    localparam int GPR_BITS  = 8;
    localparam int GPR_IDX_W = $clog2(GPR_COUNT);

    typedef enum logic [1:0] {
        PTR_PAIR0 = 2'd0,
        PTR_PAIR1 = 2'd1,
        PTR_PAIR2 = 2'd2,
        PTR_NONE  = 2'd3
    } ptr_id_e;

    typedef struct packed {
        logic regs;
        logic io;
        logic xio;
        logic sram;
    } region_t;
endpackage

// File: rtl/gpr_region_dec.sv
module gpr_region_dec #(
    parameter int AW       = 16,
    parameter int REG_SPAN = 32,
    parameter int IO_SPAN  = 64,
    parameter int XIO_TOP  = 256,
    localparam int IOW     = $clog2(IO_SPAN)
) (
    input  logic [AW-1:0]      addr,
    output gpr_pkg::region_t   region,
    output logic [IOW-1:0]     io_idx
);
    localparam int IO_LO = REG_SPAN;
    localparam int IO_HI = REG_SPAN + IO_SPAN;

    always_comb begin
        region = '0;
        io_idx = '0;
        if (addr < AW'(IO_LO)) begin
            region.regs = 1'b1;
        end else if (addr < AW'(IO_HI)) begin
            region.io = 1'b1;
            io_idx    = IOW'(addr - AW'(IO_LO));
        end else if (addr < AW'(XIO_TOP)) begin
            region.xio = 1'b1;
        end else begin
            region.sram = 1'b1;
        end
    end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
    parameter int NUM  = 32,
    parameter int W    = 8,
    localparam int IW  = $clog2(NUM)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_wide,
    input  logic [IW-1:0]         wr_sel,
    input  logic [2*W-1:0]        wr_data,
    input  logic                  ptr_we,
    input  logic                  ptr_ok,
    input  logic [IW-1:0]         ptr_lo_idx,
    input  logic [2*W-1:0]        ptr_wdata,
    input  logic                  ds_we,
    input  logic                  ds_hit,
    input  logic [IW-1:0]         ds_idx,
    input  logic [W-1:0]          ds_wdata,
    output logic [NUM-1:0][W-1:0] regs_q
);
    typedef struct packed {
        logic [NUM-1:0][W-1:0] r;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [IW-1:0] even_idx, odd_idx, ptr_hi_idx;

    assign even_idx   = {wr_sel[IW-1:1], 1'b0};
    assign odd_idx    = {wr_sel[IW-1:1], 1'b1};
    assign ptr_hi_idx = ptr_lo_idx | IW'(1);

    // Later assignments win: data space < pointer < result port.
    always_comb begin
        bank_d = bank_q;
        if (ds_we && ds_hit) begin
            bank_d.r[ds_idx] = ds_wdata;
        end
        if (ptr_we && ptr_ok) begin
            bank_d.r[ptr_lo_idx] = ptr_wdata[W-1:0];
            bank_d.r[ptr_hi_idx] = ptr_wdata[2*W-1:W];
        end
        if (wr_en) begin
            if (wr_wide) begin
                bank_d.r[even_idx] = wr_data[W-1:0];
                bank_d.r[odd_idx]  = wr_data[2*W-1:W];
            end else begin
                bank_d.r[wr_sel]   = wr_data[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs_q = bank_q.r;
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
    parameter int NUM      = gpr_pkg::GPR_COUNT,
    parameter int W        = gpr_pkg::GPR_BITS,
    parameter int AW       = 16,
    parameter int PTR_BASE = 26,
    parameter int IO_SPAN  = 64,
    parameter int XIO_TOP  = 256,
    localparam int IW      = $clog2(NUM),
    localparam int IOW     = $clog2(IO_SPAN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_a_sel,
    output logic [W-1:0]     rd_a_data,
    input  logic [IW-1:0]    rd_b_sel,
    output logic [W-1:0]     rd_b_data,
    output logic [2*W-1:0]   rd_pair_data,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [IW-1:0]    wr_sel,
    input  logic [2*W-1:0]   wr_data,
    input  logic [1:0]       ptr_sel,
    input  logic             ptr_we,
    input  logic [2*W-1:0]   ptr_wdata,
    output logic [2*W-1:0]   ptr_rdata,
    input  logic [AW-1:0]    ds_addr,
    input  logic             ds_we,
    input  logic [W-1:0]     ds_wdata,
    output logic [W-1:0]     ds_rdata,
    output logic             sel_regs,
    output logic             sel_io,
    output logic             sel_xio,
    output logic             sel_sram,
    output logic [IOW-1:0]   io_addr
);
    logic [NUM-1:0][W-1:0] regs_q;
    gpr_pkg::region_t      region;
    logic                  ptr_ok;
    logic [IW-1:0]         ptr_lo_idx;
    logic [IW-1:0]         ds_idx;

    assign ptr_ok     = (ptr_sel != gpr_pkg::PTR_NONE);
    assign ptr_lo_idx = IW'(PTR_BASE) + IW'({ptr_sel, 1'b0});
    assign ds_idx     = ds_addr[IW-1:0];

    gpr_region_dec #(
        .AW       (AW),
        .REG_SPAN (NUM),
        .IO_SPAN  (IO_SPAN),
        .XIO_TOP  (XIO_TOP)
    ) u_dec (
        .addr   (ds_addr),
        .region (region),
        .io_idx (io_addr)
    );

    gpr_bank #(
        .NUM (NUM),
        .W   (W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_wide    (wr_wide),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ptr_we     (ptr_we),
        .ptr_ok     (ptr_ok),
        .ptr_lo_idx (ptr_lo_idx),
        .ptr_wdata  (ptr_wdata),
        .ds_we      (ds_we),
        .ds_hit     (region.regs),
        .ds_idx     (ds_idx),
        .ds_wdata   (ds_wdata),
        .regs_q     (regs_q)
    );

    assign rd_a_data    = regs_q[rd_a_sel];
    assign rd_b_data    = regs_q[rd_b_sel];
    assign rd_pair_data = {regs_q[{rd_a_sel[IW-1:1], 1'b1}],
                           regs_q[{rd_a_sel[IW-1:1], 1'b0}]};
    assign ptr_rdata    = ptr_ok ? {regs_q[ptr_lo_idx | IW'(1)], regs_q[ptr_lo_idx]}
                                 : '0;
    assign ds_rdata     = region.regs ? regs_q[ds_idx] : '0;

    assign sel_regs = region.regs;
    assign sel_io   = region.io;
    assign sel_xio  = region.xio;
    assign sel_sram = region.sram;
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
    parameter int NUM      = 32,
    parameter int W        = 8,
    parameter int AW       = 16,
    parameter int PTR_BASE = 26,
    parameter int IOW      = 6,
    localparam int IW      = $clog2(NUM)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  wr_wide,
    input logic [IW-1:0]         wr_sel,
    input logic [2*W-1:0]        wr_data,
    input logic [1:0]            ptr_sel,
    input logic                  ptr_we,
    input logic [2*W-1:0]        ptr_wdata,
    input logic [AW-1:0]         ds_addr,
    input logic                  ds_we,
    input logic [W-1:0]          ds_wdata,
    input logic [IW-1:0]         rd_a_sel,
    input logic [W-1:0]          rd_a_data,
    input logic                  sel_regs,
    input logic                  sel_io,
    input logic                  sel_xio,
    input logic                  sel_sram,
    input logic [IOW-1:0]        io_addr,
    input logic [NUM-1:0][W-1:0] regs_q
);
    logic [IW-1:0] chk_plo;
    assign chk_plo = IW'(PTR_BASE + 2 * int'(ptr_sel));

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_regs, sel_io, sel_xio, sel_sram}) == 1); // R9

    AST_IO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        sel_io |-> io_addr == IOW'(ds_addr - AW'(NUM))); // R10

    AST_NARROW_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide) |=> regs_q[$past(wr_sel)] == $past(wr_data[W-1:0])); // R3

    AST_WIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide) |=> regs_q[{$past(wr_sel[IW-1:1]), 1'b0}] == $past(wr_data[W-1:0])); // R4

    AST_WIDE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide) |=> regs_q[{$past(wr_sel[IW-1:1]), 1'b1}] == $past(wr_data[2*W-1:W])); // R4

    AST_PTR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_sel != 2'd3 && !wr_en) |=>
        {regs_q[$past(chk_plo) | IW'(1)], regs_q[$past(chk_plo)]} == $past(ptr_wdata)); // R6

    AST_DS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_we && sel_regs && !wr_en && !ptr_we) |=>
        regs_q[$past(ds_addr[IW-1:0])] == $past(ds_wdata)); // R8

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ptr_we && !ds_we) |=>
        (rd_a_sel != $past(rd_a_sel) || rd_a_data == $past(rd_a_data))); // R2
endmodule

bind gpr_file gpr_file_chk #(
    .NUM      (NUM),
    .W        (W),
    .AW       (AW),
    .PTR_BASE (PTR_BASE),
    .IOW      (IOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_wide   (wr_wide),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ptr_sel   (ptr_sel),
    .ptr_we    (ptr_we),
    .ptr_wdata (ptr_wdata),
    .ds_addr   (ds_addr),
    .ds_we     (ds_we),
    .ds_wdata  (ds_wdata),
    .rd_a_sel  (rd_a_sel),
    .rd_a_data (rd_a_data),
    .sel_regs  (sel_regs),
    .sel_io    (sel_io),
    .sel_xio   (sel_xio),
    .sel_sram  (sel_sram),
    .io_addr   (io_addr),
    .regs_q    (regs_q)
);

// File: tb/gpr_file_tb.sv
`timescale 1ns/1ps
module gpr_file_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [7:0]  rd_a_data, rd_b_data, ds_rdata, ds_wdata = '0;
    logic [15:0] rd_pair_data, wr_data = '0, ptr_wdata = '0, ptr_rdata, ds_addr = '0;
    logic        wr_en = 1'b0, wr_wide = 1'b0, ptr_we = 1'b0, ds_we = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic        sel_regs, sel_io, sel_xio, sel_sram;
    logic [5:0]  io_addr;

    always #4 clk = ~clk;

    gpr_file u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data), .rd_pair_data(rd_pair_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
        .ptr_sel(ptr_sel), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
        .sel_regs(sel_regs), .sel_io(sel_io), .sel_xio(sel_xio), .sel_sram(sel_sram),
        .io_addr(io_addr)
    );

    typedef struct {
        string       req;
        int          port;
        logic [15:0] exp;
    } item_t;

    item_t      sb_q[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;
    logic [7:0] mdl [32];

    function automatic logic [15:0] port_val(int p);
        case (p)
            0: return {8'h00, rd_a_data};
            1: return {8'h00, rd_b_data};
            2: return rd_pair_data;
            3: return ptr_rdata;
            4: return {8'h00, ds_rdata};
            5: return {12'h000, sel_regs, sel_io, sel_xio, sel_sram};
            default: return {10'h000, io_addr};
        endcase
    endfunction

    // Monitor: compares all items queued for this cycle at the falling edge.
    always @(negedge clk) begin
        item_t it;
        logic [15:0] act;
        while (sb_q.size() > 0) begin
            it  = sb_q.pop_front();
            act = port_val(it.port);
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s port%0d actual=%h expected=%h", it.req, it.port, act, it.exp);
            end
        end
    end

    task automatic expect_v(string r, int p, logic [15:0] v);
        sb_q.push_back('{r, p, v});
    endtask

    task automatic nxt();
        @(posedge clk);
        #2;
        wr_en = 1'b0; wr_wide = 1'b0; ptr_we = 1'b0; ds_we = 1'b0;
    endtask

    // Model of the edge: data space first, then pointer, then result (R11).
    task automatic commit();
        if (ds_we && ds_addr < 16'h0020) mdl[ds_addr[4:0]] = ds_wdata;
        if (ptr_we && ptr_sel != 2'd3) begin
            mdl[26 + 2 * int'(ptr_sel)] = ptr_wdata[7:0];
            mdl[27 + 2 * int'(ptr_sel)] = ptr_wdata[15:8];
        end
        if (wr_en) begin
            if (wr_wide) begin
                mdl[{wr_sel[4:1], 1'b0}] = wr_data[7:0];
                mdl[{wr_sel[4:1], 1'b1}] = wr_data[15:8];
            end else begin
                mdl[wr_sel] = wr_data[7:0];
            end
        end
    endtask

    function automatic logic [15:0] ptr_exp(int p);
        return {mdl[27 + 2 * p], mdl[26 + 2 * p]};
    endfunction

    function automatic logic [15:0] region_exp(logic [15:0] a);
        if (a < 16'h0020)      return 16'h0008;
        else if (a < 16'h0060) return 16'h0004;
        else if (a < 16'h0100) return 16'h0002;
        else                   return 16'h0001;
    endfunction

    function automatic logic [15:0] io_exp(logic [15:0] a);
        if (a >= 16'h0020 && a < 16'h0060) return a - 16'h0020;
        return 16'h0000;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] addrs [8];
        addrs = '{16'h001F, 16'h0020, 16'h005F, 16'h0060,
                  16'h00FF, 16'h0100, 16'h0120, 16'hFFFF};
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: every register zero after reset
        for (int i = 0; i < 32; i++) begin
            nxt();
            rd_a_sel = 5'(i); rd_b_sel = 5'(31 - i); ds_addr = 16'(i);
            expect_v("R1", 0, 16'h0000);
            expect_v("R1", 1, 16'h0000);
            expect_v("R1", 4, 16'h0000);
        end

        // R3: byte write, same-cycle read returns old value
        nxt();
        wr_en = 1'b1; wr_sel = 5'd5; wr_data = 16'h77A5; rd_a_sel = 5'd5;
        expect_v("R3", 0, {8'h00, mdl[5]});
        commit();
        nxt();
        rd_a_sel = 5'd5; rd_b_sel = 5'd5;
        expect_v("R3", 0, 16'h00A5);
        expect_v("R2", 1, 16'h00A5);

        // R4: wide write with odd selector, bit 0 ignored; R5 pair read
        nxt();
        wr_en = 1'b1; wr_wide = 1'b1; wr_sel = 5'd9; wr_data = 16'h1234;
        commit();
        nxt();
        rd_a_sel = 5'd8; rd_b_sel = 5'd9;
        expect_v("R4", 0, 16'h0034);
        expect_v("R4", 1, 16'h0012);
        expect_v("R5", 2, 16'h1234);
        nxt();
        rd_a_sel = 5'd9;
        expect_v("R5", 2, 16'h1234);

        // R2/R5/R8: fill all registers, read back through every read path
        for (int i = 0; i < 32; i++) begin
            nxt();
            wr_en = 1'b1; wr_sel = 5'(i); wr_data = 16'(i * 37 + 11);
            commit();
        end
        for (int i = 0; i < 32; i += 2) begin
            nxt();
            rd_a_sel = 5'(i); rd_b_sel = 5'(i + 1); ds_addr = 16'(i + 1);
            expect_v("R2", 0, {8'h00, mdl[i]});
            expect_v("R2", 1, {8'h00, mdl[i + 1]});
            expect_v("R5", 2, {mdl[i + 1], mdl[i]});
            expect_v("R8", 4, {8'h00, mdl[i + 1]});
        end

        // R6: pointer loads and reads
        nxt();
        ptr_sel = 2'd0; ptr_we = 1'b1; ptr_wdata = 16'hBEEF;
        expect_v("R6", 3, ptr_exp(0));
        commit();
        nxt();
        ptr_sel = 2'd0; rd_a_sel = 5'd26; rd_b_sel = 5'd27;
        expect_v("R6", 3, 16'hBEEF);
        expect_v("R6", 0, 16'h00EF);
        expect_v("R6", 1, 16'h00BE);
        for (int p = 1; p < 3; p++) begin
            nxt();
            ptr_sel = 2'(p); ptr_we = 1'b1; ptr_wdata = 16'hC0DE + 16'(p);
            commit();
            nxt();
            ptr_sel = 2'(p); rd_a_sel = 5'(26 + 2 * p); rd_b_sel = 5'(27 + 2 * p);
            expect_v("R6", 3, 16'hC0DE + 16'(p));
            expect_v("R6", 0, {8'h00, mdl[26 + 2 * p]});
            expect_v("R6", 1, {8'h00, mdl[27 + 2 * p]});
        end

        // R7: pointer code 3 reads zero and writes nothing
        nxt();
        ptr_sel = 2'd3; ptr_we = 1'b1; ptr_wdata = 16'hDEAD;
        expect_v("R7", 3, 16'h0000);
        commit();
        for (int p = 0; p < 3; p++) begin
            nxt();
            ptr_sel = 2'(p);
            expect_v("R7", 3, ptr_exp(p));
        end

        // R8: data-space writes inside and outside the register window
        nxt();
        ds_we = 1'b1; ds_addr = 16'h0003; ds_wdata = 8'h5C;
        commit();
        nxt();
        ds_addr = 16'h0003; rd_a_sel = 5'd3;
        expect_v("R8", 4, 16'h005C);
        expect_v("R8", 0, 16'h005C);
        nxt();
        ds_we = 1'b1; ds_addr = 16'h0040; ds_wdata = 8'hFF;
        expect_v("R8", 4, 16'h0000);
        commit();
        nxt();
        ds_we = 1'b1; ds_addr = 16'h0120; ds_wdata = 8'hEE;
        expect_v("R8", 4, 16'h0000);
        commit();
        nxt();
        ds_addr = 16'h0000; rd_a_sel = 5'd0;
        expect_v("R8", 0, {8'h00, mdl[0]});
        expect_v("R8", 4, {8'h00, mdl[0]});

        // R9 and R10: region boundaries and I/O index
        for (int k = 0; k < 8; k++) begin
            nxt();
            ds_addr = addrs[k];
            expect_v("R9", 5, region_exp(addrs[k]));
            expect_v("R10", 6, io_exp(addrs[k]));
        end

        // R11: same-cycle conflicts between write ports
        nxt();
        wr_en = 1'b1; wr_sel = 5'd26; wr_data = 16'h0011;
        ptr_we = 1'b1; ptr_sel = 2'd0; ptr_wdata = 16'h2233;
        ds_we = 1'b1; ds_addr = 16'h001A; ds_wdata = 8'h44;
        commit();
        nxt();
        rd_a_sel = 5'd26; rd_b_sel = 5'd27;
        expect_v("R11", 0, 16'h0011);
        expect_v("R11", 1, 16'h0022);
        nxt();
        ptr_we = 1'b1; ptr_sel = 2'd0; ptr_wdata = 16'h5566;
        ds_we = 1'b1; ds_addr = 16'h001B; ds_wdata = 8'h77;
        commit();
        nxt();
        rd_a_sel = 5'd26; rd_b_sel = 5'd27;
        expect_v("R11", 0, 16'h0066);
        expect_v("R11", 1, 16'h0055);
        nxt();
        wr_en = 1'b1; wr_wide = 1'b1; wr_sel = 5'd30; wr_data = 16'hAABB;
        ptr_we = 1'b1; ptr_sel = 2'd2; ptr_wdata = 16'h1122;
        commit();
        nxt();
        ptr_sel = 2'd2;
        expect_v("R11", 3, 16'hAABB);

        nxt();
        nxt();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule